// File: doc/BRIEF.md
# Tributary Bit Justification Buffer

This block carries one plesiochronous serial tributary into a per-tributary timeslot stream that runs slightly faster and has gaps. Tributary bits enter a small single-bit elastic store when the write strobe is high. The frame sequencer pulls them out with a read strobe, and it leaves that strobe low at the fixed overhead positions of the frame. Each frame has one justification opportunity, the stuffable slot, and it can carry a data bit or nothing. Even with the fixed gaps the output capacity exceeds the fastest allowed input rate. Stuffing the opportunity slot in some frames and not in others brings the average drain rate exactly onto the input rate.

Once per frame the sequencer pulses a decide strobe. At that strobe the block takes the difference between its write and read addresses, which is the fill level. A fill below half depth means the tributary is running behind, so the frame is stuffed. At the stuffable slot the block then skips the read. At any other fill the stuffable slot carries a data bit. The decision stays latched until the end of the frame, so the framer can place it in the justification control bits before the slot comes round. A needed stuff cannot act before the fixed slot. Overflow and underflow set sticky error flags. A synchronous reset clears the store and puts the write address half a store ahead of the read address.

The justification controller is a three-state machine. State JS_COLLECT waits for the frame's decision. The transition COLLECT→HOLD_STUFF is taken on decide when the fill is below half depth. The transition COLLECT→HOLD_DATA is taken on decide at any other fill. The transitions HOLD_DATA→COLLECT and HOLD_STUFF→COLLECT are taken on frame_end. In both hold states a further decide is ignored.

Top module: `tbj_justify_buffer`

## Requirements
- R1: After reset the fill level is DEPTH/2, stuff_flag, decision_valid, rd_valid, overflow_err and underflow_err are 0, and every stored bit is 0.
- R2: Bits leave in the order they were written. A bit read in cycle N appears on rd_bit with rd_valid=1 in cycle N+1.
- R3: fill_level equals the written count minus the read count since reset, offset by DEPTH/2, and never exceeds DEPTH.
- R4: On decide in state JS_COLLECT, stuff_flag becomes 1 in the next cycle if the fill at the strobe was below DEPTH/2. Otherwise it becomes 0. decision_valid becomes 1 in both cases.
- R5: A stuff_slot pulse in JS_HOLD_DATA reads one bit. A stuff_slot pulse in JS_HOLD_STUFF or in JS_COLLECT reads nothing: rd_valid stays 0 and the fill is unchanged.
- R6: While decision_valid is 1, stuff_flag holds its value until frame_end, even across further decide pulses or fill changes. The cycle after frame_end, decision_valid is 0.
- R7: A write while the fill is DEPTH, and no read in the same cycle, is dropped and sets overflow_err. overflow_err stays at 1 until reset.
- R8: A read request while the fill is 0 moves nothing, gives rd_valid=0 and sets underflow_err. underflow_err stays at 1 until reset.
- R9: Reset in mid-run restores the R1 state, including the centred addresses.
- R10: In a cycle with rd_en and stuff_slot both low (an overhead gap), nothing is read and rd_valid is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Tributary bit strobe |
| wr_bit | input | 1 | Tributary data bit |
| rd_en | input | 1 | Data-slot read strobe from the sequencer (low in overhead gaps) |
| stuff_slot | input | 1 | Marks the stuffable slot; never high together with rd_en |
| decide | input | 1 | Once-per-frame decision strobe |
| frame_end | input | 1 | Last cycle of the frame |
| rd_bit | output | 1 | Bit read out, registered |
| rd_valid | output | 1 | rd_bit carries a data bit |
| stuff_flag | output | 1 | Latched decision: 1 means the stuffable slot is empty |
| decision_valid | output | 1 | A decision is held for the current frame |
| fill_level | output | $clog2(DEPTH)+1 | Write address minus read address |
| overflow_err | output | 1 | Sticky overflow flag |
| underflow_err | output | 1 | Sticky underflow flag |

## Verification
The bench builds the block with the default DEPTH of 16, so half depth is 8 and the address difference is five bits wide. At this size, eight writes after reset fill the store and sixteen reads drain it. That puts overflow, underflow and the decision boundary at exactly eight bits a few cycles from reset. A sixteen-bit sequence is enough to check the read order across the wrap of the address.

// File: rtl/tbj_pkg.sv
package tbj_pkg;
    typedef enum logic [1:0] {
        JS_COLLECT    = 2'd0,
        JS_HOLD_DATA  = 2'd1,
        JS_HOLD_STUFF = 2'd2
    } just_state_e;
endpackage

// File: rtl/tbj_store.sv
module tbj_store #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic          rdata,
    output logic          rvalid
);
    logic [DEPTH-1:0] cells_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cells_q <= '0;
        end else if (we) begin
            cells_q[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= 1'b0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= re;
            rdata  <= re ? cells_q[raddr] : 1'b0;
        end
    end

    // R2: a read in one cycle gives a valid bit in the next
    assert_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
        re |=> rvalid);
    assert_idle_no_valid_R10: assert property (@(posedge clk) disable iff (rst)
        !re |=> !rvalid);
endmodule

// File: rtl/tbj_pointers.sv
module tbj_pointers #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int FW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic          rd_req,
    output logic          wr_do,
    output logic          rd_do,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [FW-1:0] fill,
    output logic          ovf_err,
    output logic          unf_err
);
    localparam logic [FW-1:0] HALF_FILL = FW'(DEPTH / 2);
    localparam logic [FW-1:0] FULL_FILL = FW'(DEPTH);

    logic [FW-1:0] wr_ptr_q, rd_ptr_q;
    logic          full, empty;

    assign fill    = wr_ptr_q - rd_ptr_q;
    assign full    = (fill == FULL_FILL);
    assign empty   = (fill == '0);
    assign rd_do   = rd_req && !empty;
    assign wr_do   = wr_req && (!full || rd_do);
    assign wr_addr = wr_ptr_q[AW-1:0];
    assign rd_addr = rd_ptr_q[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= HALF_FILL;
            rd_ptr_q <= '0;
            ovf_err  <= 1'b0;
            unf_err  <= 1'b0;
        end else begin
            if (wr_do) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (rd_do) rd_ptr_q <= rd_ptr_q + 1'b1;
            if (wr_req && !wr_do) ovf_err <= 1'b1;
            if (rd_req && empty)  unf_err <= 1'b1;
        end
    end

    assert_fill_bound_R3: assert property (@(posedge clk) disable iff (rst)
        fill <= FULL_FILL);
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (full && wr_req && !rd_req) |=> (ovf_err && $stable(wr_ptr_q)));
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ovf_err |=> ovf_err);
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_req) |=> (unf_err && $stable(rd_ptr_q)));
    assert_unf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        unf_err |=> unf_err);
endmodule

// File: rtl/tbj_just_ctrl.sv
module tbj_just_ctrl
    import tbj_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int FW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          decide,
    input  logic          frame_end,
    input  logic          stuff_slot,
    input  logic          rd_en,
    input  logic [FW-1:0] fill,
    output logic          rd_req,
    output logic          stuff_flag,
    output logic          decision_valid
);
    localparam logic [FW-1:0] HALF_FILL = FW'(DEPTH / 2);

    just_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= JS_COLLECT;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            JS_COLLECT: begin
                if (decide) begin
                    state_d = (fill < HALF_FILL) ? JS_HOLD_STUFF : JS_HOLD_DATA;
                end
            end
            JS_HOLD_DATA:  if (frame_end) state_d = JS_COLLECT;
            JS_HOLD_STUFF: if (frame_end) state_d = JS_COLLECT;
            default:       state_d = JS_COLLECT;
        endcase
    end

    always_comb begin
        stuff_flag     = 1'b0;
        decision_valid = 1'b0;
        rd_req         = rd_en;
        unique case (state_q)
            JS_COLLECT: ;
            JS_HOLD_DATA: begin
                decision_valid = 1'b1;
                rd_req         = rd_en || stuff_slot;
            end
            JS_HOLD_STUFF: begin
                decision_valid = 1'b1;
                stuff_flag     = 1'b1;
            end
            default: ;
        endcase
    end

    assert_decide_R4: assert property (@(posedge clk) disable iff (rst)
        (!decision_valid && decide) |=>
            (decision_valid && (stuff_flag == ($past(fill) < HALF_FILL))));
    assert_flag_held_R6: assert property (@(posedge clk) disable iff (rst)
        (decision_valid && !frame_end) |=> (decision_valid && $stable(stuff_flag)));
    assert_frame_close_R6: assert property (@(posedge clk) disable iff (rst)
        (decision_valid && frame_end) |=> !decision_valid);
endmodule

// File: rtl/tbj_justify_buffer.sv
module tbj_justify_buffer #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int FW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_bit,
    input  logic          rd_en,
    input  logic          stuff_slot,
    input  logic          decide,
    input  logic          frame_end,
    output logic          rd_bit,
    output logic          rd_valid,
    output logic          stuff_flag,
    output logic          decision_valid,
    output logic [FW-1:0] fill_level,
    output logic          overflow_err,
    output logic          underflow_err
);
    logic          rd_req, rd_do, wr_do;
    logic [AW-1:0] wr_addr, rd_addr;

    tbj_just_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk(clk), .rst(rst), .decide(decide), .frame_end(frame_end),
        .stuff_slot(stuff_slot), .rd_en(rd_en), .fill(fill_level),
        .rd_req(rd_req), .stuff_flag(stuff_flag), .decision_valid(decision_valid)
    );

    tbj_pointers #(.DEPTH(DEPTH)) ptr_i (
        .clk(clk), .rst(rst), .wr_req(wr_en), .rd_req(rd_req),
        .wr_do(wr_do), .rd_do(rd_do), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .fill(fill_level), .ovf_err(overflow_err), .unf_err(underflow_err)
    );

    tbj_store #(.DEPTH(DEPTH)) store_i (
        .clk(clk), .rst(rst), .we(wr_do), .waddr(wr_addr), .wdata(wr_bit),
        .re(rd_do), .raddr(rd_addr), .rdata(rd_bit), .rvalid(rd_valid)
    );

    // R5: an empty stuffable slot on a stuffed frame yields no data bit
    assert_stuffed_slot_empty_R5: assert property (@(posedge clk) disable iff (rst)
        (stuff_flag && stuff_slot && !rd_en) |=> !rd_valid);
    assert_gap_no_read_R10: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !stuff_slot) |=> (!rd_valid && fill_level >= $past(fill_level)));
endmodule

// File: tb/tbj_justify_buffer_tb_top.sv
module tbj_justify_buffer_tb_top;
    localparam int DEPTH = 16;
    localparam int FW = $clog2(DEPTH) + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0, wr_bit = 1'b0, rd_en = 1'b0;
    logic stuff_slot = 1'b0, decide = 1'b0, frame_end = 1'b0;
    logic rd_bit, rd_valid, stuff_flag, decision_valid, overflow_err, underflow_err;
    logic [FW-1:0] fill_level;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tbj_justify_buffer #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bit(wr_bit), .rd_en(rd_en),
        .stuff_slot(stuff_slot), .decide(decide), .frame_end(frame_end),
        .rd_bit(rd_bit), .rd_valid(rd_valid), .stuff_flag(stuff_flag),
        .decision_valid(decision_valid), .fill_level(fill_level),
        .overflow_err(overflow_err), .underflow_err(underflow_err)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one clock: inputs already set at a negedge, sample at the next negedge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        wr_en = 0; rd_en = 0; stuff_slot = 0; decide = 0; frame_end = 0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst = 1; tick(); tick();
        rst = 0;
    endtask

    task automatic write_bit(input logic b);
        wr_en = 1; wr_bit = b; tick(); wr_en = 0;
    endtask

    task automatic test_reset_state();
        do_reset();
        check("R1", "fill", fill_level, DEPTH / 2);
        check("R1", "flags", {stuff_flag, decision_valid, rd_valid, overflow_err, underflow_err}, 0);
    endtask

    task automatic test_order_and_underflow();
        logic [15:0] pat = 16'b1011_0010_1100_0111;
        do_reset();
        for (int i = 0; i < 8; i++) write_bit(pat[i]);
        check("R3", "fill after 8 writes", fill_level, 16);
        for (int i = 0; i < 16; i++) begin
            rd_en = 1; tick(); rd_en = 0;
            check("R2", "rd_valid", rd_valid, 1);
            check("R2", $sformatf("bit %0d", i), rd_bit, (i < 8) ? 0 : pat[i-8]);
        end
        check("R3", "fill drained", fill_level, 0);
        rd_en = 1; tick(); rd_en = 0;
        check("R8", "rd_valid on empty", rd_valid, 0);
        check("R8", "underflow_err", underflow_err, 1);
        check("R8", "fill stays 0", fill_level, 0);
        tick(); tick();
        check("R8", "underflow sticky", underflow_err, 1);
        check("R7", "no overflow", overflow_err, 0);
    endtask

    task automatic test_overflow_and_reset();
        do_reset();
        for (int i = 0; i < 8; i++) write_bit(1'b1);
        check("R7", "no overflow at full", overflow_err, 0);
        write_bit(1'b0);
        check("R7", "overflow_err", overflow_err, 1);
        check("R7", "fill held at DEPTH", fill_level, 16);
        tick(); tick();
        check("R7", "overflow sticky", overflow_err, 1);
        do_reset();
        check("R9", "fill recentred", fill_level, DEPTH / 2);
        check("R9", "errors cleared", {overflow_err, underflow_err}, 0);
        // recentred store holds zeros
        rd_en = 1; tick(); rd_en = 0;
        check("R9", "cleared bit", rd_bit, 0);
    endtask

    task automatic test_decisions();
        do_reset();
        // overhead gap: nothing moves
        tick();
        check("R10", "gap rd_valid", rd_valid, 0);
        check("R10", "gap fill", fill_level, 8);
        // stuffable slot with no decision yet reads nothing
        stuff_slot = 1; tick(); stuff_slot = 0;
        check("R5", "collect slot rd_valid", rd_valid, 0);
        check("R5", "collect slot fill", fill_level, 8);
        // fill exactly half: data frame
        decide = 1; tick(); decide = 0;
        check("R4", "decision_valid", decision_valid, 1);
        check("R4", "half fill no stuff", stuff_flag, 0);
        stuff_slot = 1; tick(); stuff_slot = 0;
        check("R5", "data slot rd_valid", rd_valid, 1);
        check("R5", "data slot fill", fill_level, 7);
        frame_end = 1; tick(); frame_end = 0;
        check("R6", "closed after frame_end", decision_valid, 0);
        // fill 7: stuffed frame
        decide = 1; tick(); decide = 0;
        check("R4", "below half stuff", stuff_flag, 1);
        stuff_slot = 1; tick(); stuff_slot = 0;
        check("R5", "stuffed slot rd_valid", rd_valid, 0);
        check("R5", "stuffed slot fill", fill_level, 7);
        write_bit(1'b1); write_bit(1'b0);
        decide = 1; tick(); decide = 0;
        check("R6", "flag held after fill 9 and decide", stuff_flag, 1);
        check("R6", "still valid", decision_valid, 1);
        frame_end = 1; tick(); frame_end = 0;
        check("R6", "closed", decision_valid, 0);
        check("R6", "flag low in collect", stuff_flag, 0);
        decide = 1; tick(); decide = 0;
        check("R4", "fill 9 no stuff", stuff_flag, 0);
    endtask

    initial begin
        @(negedge clk);
        test_reset_state();
        test_order_and_underflow();
        test_overflow_and_reset();
        test_decisions();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule